// File: doc/BRIEF.md
# SPI Port with Status Flags

This block is a byte-wide SPI port that a processor controls through a small register window. It holds a control register, a status register and a data register. It can act as the bus master, driving SCK and MOSI and reading MISO, or as a slave, which follows SCK, reads MOSI and drives MISO while its active-low select input is held low. Every exchange is full duplex: while one byte shifts out most significant bit first, the byte from the other side shifts in. The processor can then read that received byte from the data register.

A three-state machine sequences each exchange. In `S_IDLE` the transmit shift register tracks the staged byte. `S_IDLE -> S_XFER` happens on one of three events: a master start (a data write in master mode), a falling edge of the select input for a slave in phase mode 0, or the first leading SCK edge while the slave is selected in phase mode 1. `S_XFER -> S_IDLE` happens after the sixteenth SCK edge for a master or a phase-1 slave, or when the exchange is aborted. An abort comes from a mode fault, a dropped select or a dropped enable. `S_XFER -> S_HOLD` happens after the sixteenth edge for a phase-0 slave. `S_HOLD -> S_IDLE` happens once the select input goes high.

The status flags report a completed exchange, a write collision and a mode fault. The flags are cleared by a two-step sequence: a status read must come before the clearing access. The interrupt line combines the completion and fault flags with an enable bit. An output mode selectable by a control bit lets the pins only pull low, for shared wired-AND buses.

Top module: `spi_port`

## Requirements
- R1: After reset the control register (offset 0) and the status register (offset 1) both read 0, so the wired-low mode is off, every output enable is low and `irq` is low.
- R2: With control bits enable (bit 0) and master (bit 1) set and no exchange running, a write to the data register (offset 2) exchanges 8 bits MSB first in both directions. The byte received from MISO is then read back from offset 2.
- R3: SCK rests at the level of control bit 2 (CPOL) between exchanges. With control bit 3 (CPHA) at 0, data is sampled on the leading edge and valid before it. With CPHA at 1, data changes on the leading edge and is sampled on the trailing edge. An exchange has exactly 16 SCK edges.
- R4: Control bits [7:6] set the master SCK period to 2, 4, 16 or 32 system clocks for codes 0, 1, 2 and 3.
- R5: Status bit 0 sets when an exchange completes. It clears only when a status read that saw it set is followed by a read or write of offset 2. A data access without that earlier status read leaves it set.
- R6: A data write during an exchange sets status bit 1 and is discarded, and the bytes on both lines are unaffected. Bit 1 clears by the same sequence as bit 0.
- R7: If the select input is low while enable and master are both set, status bit 2 sets, control bits 0 and 1 clear, and the SCK and MOSI output enables fall. Bit 2 clears when a status read that saw it set is followed by a control write.
- R8: A phase-0 slave starts an exchange on a falling edge of the select input. After one byte it ignores further SCK edges until the select input has gone high and low again.
- R9: A phase-1 slave starts an exchange on the first leading SCK edge while selected. It exchanges successive bytes with the select input held low throughout.
- R10: `miso_oe` is high only while the port is enabled, in slave mode and selected.
- R11: With control bit 4 set, an output enable is high only while its output value is 0.
- R12: `irq` is high exactly when control bit 5 is set and status bit 0 or status bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register offset: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives clearing side effects) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | SCK pin level (slave clock) |
| sck_o | output | 1 | SCK output value |
| sck_oe | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI pin level (slave data in) |
| mosi_o | output | 1 | MOSI output value |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin level (master data in) |
| miso_o | output | 1 | MISO output value |
| miso_oe | output | 1 | MISO output enable |
| ss_n_i | input | 1 | Active-low slave select / fault sense |

## Verification
As master, the bench sweeps all four clock modes across all four rates. A model slave on the pins checks the sixteen edges, the spacing between them, the idle level and both data directions. A wrong phase choice would shift the received bytes by one bit, and a wrong divider would show up as a wrong edge spacing. The clearing order is probed by reading data before reading status: a design that clears on any data access would lose the flag. A collision write mid-exchange must leave both bytes intact. A phase-0 slave clocked again without a select toggle must not report a second byte, and a mode fault must drop the enables and release the pins at once.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_XFER,
        S_HOLD
    } xfer_state_e;

    // control register layout, MSB first
    typedef struct packed {
        logic [1:0] rate;
        logic       irq_en;
        logic       wired;
        logic       cpha;
        logic       cpol;
        logic       master;
        logic       en;
    } ctrl_t;

    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_STAT = 2'd1;
    localparam logic [1:0] OFS_DATA = 2'd2;

    // output enable for one pad; in wired mode a 1 is left to the pull-up
    function automatic logic pad_enable(logic drive, logic wired, logic value);
        return drive & ~(wired & value);
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      pipe[g] <= RST_VAL;
                else if (g == 0) pipe[g] <= d;
                else             pipe[g] <= pipe[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
    parameter int DIV_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    // half period in system clocks: 1, 2, 8, 16
    always_comb begin
        unique case (rate)
            2'd0:    limit = DIV_W'(0);
            2'd1:    limit = DIV_W'(1);
            2'd2:    limit = DIV_W'(7);
            default: limit = DIV_W'(15);
        endcase
    end

    assign tick = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (!run) cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              is_master,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              abort,
    input  logic              start,
    input  logic              tick,
    input  logic              s_sck,
    input  logic              s_ss_n,
    input  logic              s_mosi,
    input  logic              m_miso,
    input  logic [DATA_W-1:0] tx_data,
    output logic              busy,
    output logic              done,
    output logic              sdo,
    output logic              sck_lvl,
    output logic [DATA_W-1:0] rx_data
);
    localparam int EDGES = 2 * DATA_W;
    localparam int CNT_W = $clog2(EDGES);

    xfer_state_e       state, state_n;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] tx_sh, rx_sh;
    logic              sck_q, sck_prev, ss_prev;

    logic slave_sel, sck_chg, edge_ev, sample_now, shift_now, last_edge;
    logic slave_go0, slave_go1, in_bit;

    assign slave_sel  = enable & ~is_master & ~s_ss_n;
    assign sck_chg    = (s_sck != sck_prev);
    assign edge_ev    = (state == S_XFER) && (is_master ? tick : sck_chg);
    assign sample_now = edge_ev && (cnt[0] == cpha);
    assign shift_now  = edge_ev && (cnt[0] != cpha) && !(cpha && cnt == '0);
    assign last_edge  = edge_ev && (cnt == CNT_W'(EDGES - 1));
    assign slave_go0  = slave_sel && !cpha && ss_prev;
    assign slave_go1  = slave_sel && cpha && sck_chg && (s_sck != cpol);
    assign in_bit     = is_master ? m_miso : s_mosi;

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: begin
                if (abort)                              state_n = S_IDLE;
                else if (is_master && enable && start)  state_n = S_XFER;
                else if (slave_go0 || slave_go1)        state_n = S_XFER;
            end
            S_XFER: begin
                if (abort || !enable)                   state_n = S_IDLE;
                else if (!is_master && s_ss_n)          state_n = S_IDLE;
                else if (last_edge)
                    state_n = (is_master || cpha) ? S_IDLE : S_HOLD;
            end
            S_HOLD: begin
                if (s_ss_n || is_master || !enable || abort) state_n = S_IDLE;
            end
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            sck_q    <= 1'b0;
            sck_prev <= 1'b0;
            ss_prev  <= 1'b1;
            done     <= 1'b0;
        end else begin
            sck_prev <= s_sck;
            ss_prev  <= s_ss_n;
            done     <= 1'b0;
            if (state != S_XFER) begin
                tx_sh <= tx_data;
                sck_q <= cpol;
                cnt   <= slave_go1 ? CNT_W'(1) : '0;
            end else if (edge_ev) begin
                sck_q <= ~sck_q;
                cnt   <= cnt + 1'b1;
                if (sample_now) rx_sh <= {rx_sh[DATA_W-2:0], in_bit};
                if (shift_now)  tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                if (last_edge && state_n != S_IDLE) done <= 1'b1;
                if (last_edge && is_master && enable && !abort) done <= 1'b1;
                if (last_edge && cpha && !is_master && !s_ss_n && enable && !abort) done <= 1'b1;
            end
        end
    end

    assign busy    = (state == S_XFER);
    assign sdo     = tx_sh[DATA_W-1];
    assign sck_lvl = sck_q;
    assign rx_data = rx_sh;

    // R2: completion is a single-cycle pulse
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a phase-0 slave holding after a byte does not restart while still selected
    p_hold_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD && !s_ss_n && !abort) |=> (state != S_XFER));
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_n_i
);
    ctrl_t             ctrl_q;
    logic              flag_spif, flag_wcol, flag_fault;
    logic [2:0]        armed;
    logic [DATA_W-1:0] tx_buf, rx_buf;
    logic              start_q;

    logic              s_sck, s_ss_n, s_mosi;
    logic              tick, eng_busy, eng_done, eng_sdo, eng_sck;
    logic [DATA_W-1:0] eng_rx;

    logic ctrl_wr, stat_rd, data_wr, data_acc, busy_all, fault_cond;
    logic m_drive, s_drive;

    assign ctrl_wr    = wr_en && addr == OFS_CTRL;
    assign stat_rd    = rd_en && addr == OFS_STAT;
    assign data_wr    = wr_en && addr == OFS_DATA;
    assign data_acc   = (wr_en || rd_en) && addr == OFS_DATA;
    assign busy_all   = eng_busy || start_q;
    assign fault_cond = ctrl_q.en && ctrl_q.master && !s_ss_n;

    spi_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({sck_i, ss_n_i, mosi_i}),
        .q({s_sck, s_ss_n, s_mosi})
    );

    spi_rate_gen #(.DIV_W(4)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(eng_busy && ctrl_q.master),
        .rate(ctrl_q.rate), .tick(tick)
    );

    spi_shift_engine #(.DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .enable(ctrl_q.en), .is_master(ctrl_q.master),
        .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha),
        .abort(fault_cond), .start(start_q), .tick(tick),
        .s_sck(s_sck), .s_ss_n(s_ss_n), .s_mosi(s_mosi), .m_miso(miso_i),
        .tx_data(tx_buf),
        .busy(eng_busy), .done(eng_done), .sdo(eng_sdo),
        .sck_lvl(eng_sck), .rx_data(eng_rx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            flag_spif  <= 1'b0;
            flag_wcol  <= 1'b0;
            flag_fault <= 1'b0;
            armed      <= '0;
            tx_buf     <= '0;
            rx_buf     <= '0;
            start_q    <= 1'b0;
        end else begin
            start_q <= data_wr && !busy_all && ctrl_q.en && ctrl_q.master && !fault_cond;
            if (data_wr && !busy_all) tx_buf <= wdata;
            if (eng_done)             rx_buf <= eng_rx;

            if (ctrl_wr) ctrl_q <= ctrl_t'(wdata[7:0]);
            if (fault_cond) begin
                ctrl_q.en     <= 1'b0;
                ctrl_q.master <= 1'b0;
            end

            if (eng_done)                  flag_spif <= 1'b1;
            else if (data_acc && armed[0]) flag_spif <= 1'b0;

            if (data_wr && busy_all)       flag_wcol <= 1'b1;
            else if (data_acc && armed[1]) flag_wcol <= 1'b0;

            if (fault_cond)                flag_fault <= 1'b1;
            else if (ctrl_wr && armed[2])  flag_fault <= 1'b0;

            if (stat_rd) armed <= {flag_fault, flag_wcol, flag_spif};
            else begin
                if (data_acc) armed[1:0] <= 2'b00;
                if (ctrl_wr)  armed[2]   <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (addr)
            OFS_CTRL: rdata = DATA_W'(ctrl_q);
            OFS_STAT: rdata = DATA_W'({flag_fault, flag_wcol, flag_spif});
            OFS_DATA: rdata = rx_buf;
            default:  rdata = '0;
        endcase
    end

    assign m_drive = ctrl_q.en && ctrl_q.master;
    assign s_drive = ctrl_q.en && !ctrl_q.master && !s_ss_n;

    assign sck_o   = eng_sck;
    assign mosi_o  = eng_sdo;
    assign miso_o  = eng_sdo;
    assign sck_oe  = pad_enable(m_drive, ctrl_q.wired, eng_sck);
    assign mosi_oe = pad_enable(m_drive, ctrl_q.wired, eng_sdo);
    assign miso_oe = pad_enable(s_drive, ctrl_q.wired, eng_sdo);
    assign irq     = ctrl_q.irq_en && (flag_spif || flag_fault);

    // R5: a finished exchange always leaves the completion flag set
    p_done_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> flag_spif);

    // R6: a data write into a running exchange raises the collision flag
    p_collision_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && busy_all) |=> flag_wcol);

    // R7: a select seen low by an enabled master disables the port and flags it
    p_fault_disables_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_cond |=> (!ctrl_q.en && !ctrl_q.master && flag_fault));

    // R7: once disabled by a fault, the master pads are released next cycle
    p_fault_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_cond |=> (!sck_oe && !mosi_oe));
endmodule

// File: tb/spi_port_test.sv
module spi_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int SH         = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i, ss_n_i = 1'b1;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit finished = 1'b0;

    // pads with pull-ups
    wire sck_pin  = sck_oe  ? sck_o  : 1'b1;
    wire mosi_pin = mosi_oe ? mosi_o : 1'b1;

    // model slave on the bus
    bit         model_en = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0;
    logic [7:0] m_tx = '0, m_rx = '0;
    int         m_edges = 0, m_last = 0, m_half = 1, gap_bad = 0, wired_bad = 0;
    bit         wired_mon = 1'b0;
    assign miso_i = m_tx[7];

    spi_port #(.DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_n_i(ss_n_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) cyc++;

    always @(negedge clk)
        if (wired_mon && ((sck_oe && sck_o) || (mosi_oe && mosi_o))) wired_bad++;

    always @(sck_pin) begin
        if (model_en) begin
            if (m_edges > 0 && (cyc - m_last) != m_half) gap_bad++;
            m_last = cyc;
            if (((sck_pin != m_cpol) ? 1'b1 : 1'b0) ^ m_cpha)
                m_rx = {m_rx[6:0], mosi_pin};
            else if (!(m_cpha && m_edges == 0))
                m_tx = {m_tx[6:0], 1'b0};
            m_edges++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_spif(input string req);
        logic [7:0] s;
        s = '0;
        for (int n = 0; n < 3000 && !s[0]; n++) bus_rd(2'd1, s);
        chk(req, s[0], 1);
    endtask

    task automatic run_master(input bit cpol, input bit cpha, input logic [1:0] rate,
                              input bit wired, input logic [7:0] txb, input logic [7:0] slvb);
        logic [7:0] r;
        bus_wr(2'd0, {rate, 1'b0, wired, cpha, cpol, 1'b1, 1'b1});
        repeat (3) @(negedge clk);
        chk("R3 idle level", sck_pin, cpol);
        m_cpol = cpol; m_cpha = cpha; m_tx = slvb; m_rx = '0;
        m_edges = 0; gap_bad = 0; wired_bad = 0;
        m_half = (rate < 2) ? (1 << rate) : (1 << (rate + 1));
        model_en = 1'b1; wired_mon = wired;
        bus_wr(2'd2, txb);
        wait_spif("R5 done flag");
        chk("R12 irq masked", irq, 0);
        bus_rd(2'd2, r);
        chk("R2 received byte", r, slvb);
        chk("R2 sent byte", m_rx, txb);
        chk("R3 edge count", m_edges, 16);
        chk("R4 edge spacing", gap_bad, 0);
        bus_rd(2'd1, r);
        chk("R5 cleared by sequence", r, 0);
        if (wired) chk("R11 wired drive", wired_bad, 0);
        model_en = 1'b0; wired_mon = 1'b0;
    endtask

    // bench acts as master toward the slave port
    task automatic slv_byte(input bit cpol, input bit cpha, input logic [7:0] mtx,
                            output logic [7:0] got);
        got = '0;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            if (!cpha) begin
                mosi_i = mtx[i];
                repeat (SH) @(negedge clk);
                sck_i = ~cpol; got[i] = miso_o;
                repeat (SH) @(negedge clk);
                sck_i = cpol;
            end else begin
                sck_i = ~cpol; mosi_i = mtx[i];
                repeat (SH) @(negedge clk);
                sck_i = cpol; got[i] = miso_o;
                repeat (SH) @(negedge clk);
            end
        end
        repeat (SH) @(negedge clk);
    endtask

    initial begin
        logic [7:0] r, g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(2'd0, r); chk("R1 control", r, 0);
        bus_rd(2'd1, r); chk("R1 status", r, 0);
        chk("R1 sck_oe", sck_oe, 0);
        chk("R1 mosi_oe", mosi_oe, 0);
        chk("R1 miso_oe", miso_oe, 0);
        chk("R1 irq", irq, 0);

        // R2 R3 R4 sweep over modes and rates
        for (int cp = 0; cp < 2; cp++)
            for (int po = 0; po < 2; po++)
                for (int rt = 0; rt < 4; rt++)
                    for (int k = 0; k < 2; k++) begin
                        logic [7:0] t, s;
                        t = 8'((k * 91 + rt * 29 + po * 7 + cp * 3 + 90) & 255);
                        s = 8'((t * 5 + 17) & 255);
                        run_master(po[0], cp[0], rt[1:0], 1'b0, t, s);
                    end

        // R11 wired-low output mode
        run_master(1'b1, 1'b0, 2'd1, 1'b1, 8'hB4, 8'h69);
        run_master(1'b0, 1'b1, 2'd0, 1'b1, 8'h0F, 8'hE2);

        // R6 collision mid-exchange
        bus_wr(2'd0, 8'hC3);
        repeat (3) @(negedge clk);
        m_cpol = 1'b0; m_cpha = 1'b0; m_tx = 8'h96; m_rx = '0; m_edges = 0;
        m_half = 16; gap_bad = 0; model_en = 1'b1;
        bus_wr(2'd2, 8'h3C);
        repeat (40) @(negedge clk);
        bus_wr(2'd2, 8'hFF);
        bus_rd(2'd1, r);
        chk("R6 collision flag", r, 8'h02);
        wait_spif("R6 exchange completes");
        bus_rd(2'd2, r);
        chk("R6 received intact", r, 8'h96);
        chk("R6 sent intact", m_rx, 8'h3C);
        bus_rd(2'd1, r);
        chk("R6 collision cleared", r, 0);
        model_en = 1'b0;

        // R5 data access alone does not clear; R12 irq
        bus_wr(2'd0, 8'h23);
        repeat (3) @(negedge clk);
        m_cpol = 1'b0; m_cpha = 1'b0; m_tx = 8'h11; m_rx = '0; m_edges = 0;
        m_half = 1; model_en = 1'b1;
        bus_wr(2'd2, 8'h81);
        for (int n = 0; n < 500 && !irq; n++) @(negedge clk);
        chk("R12 irq on done", irq, 1);
        bus_rd(2'd2, r);
        bus_rd(2'd1, r);
        chk("R5 not cleared without status read", r, 8'h01);
        bus_rd(2'd2, r);
        chk("R2 byte after flag", r, 8'h11);
        bus_rd(2'd1, r);
        chk("R5 cleared", r, 0);
        chk("R12 irq drops", irq, 0);
        model_en = 1'b0;

        // R7 mode fault
        bus_wr(2'd0, 8'h23);
        ss_n_i = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7 sck released", sck_oe, 0);
        chk("R7 mosi released", mosi_oe, 0);
        bus_rd(2'd0, r);
        chk("R7 enables cleared", r, 8'h20);
        bus_rd(2'd1, r);
        chk("R7 fault flag", r, 8'h04);
        chk("R12 irq on fault", irq, 1);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        bus_wr(2'd0, 8'h00);
        bus_rd(2'd1, r);
        chk("R7 fault cleared", r, 0);

        // R8 R10 phase-0 slave, CPOL 1
        sck_i = 1'b1;
        bus_wr(2'd0, 8'h05);
        repeat (4) @(negedge clk);
        chk("R10 unselected miso", miso_oe, 0);
        bus_wr(2'd2, 8'hA7);
        ss_n_i = 1'b0;
        repeat (SH) @(negedge clk);
        chk("R10 selected miso", miso_oe, 1);
        slv_byte(1'b1, 1'b0, 8'h5E, g);
        chk("R8 slave sent", g, 8'hA7);
        wait_spif("R8 first byte done");
        bus_rd(2'd2, r); chk("R8 slave received", r, 8'h5E);
        ss_n_i = 1'b1;
        repeat (SH) @(negedge clk);
        chk("R10 released miso", miso_oe, 0);
        bus_wr(2'd2, 8'h3D);
        ss_n_i = 1'b0;
        repeat (SH) @(negedge clk);
        slv_byte(1'b1, 1'b0, 8'hC1, g);
        chk("R8 second sent", g, 8'h3D);
        wait_spif("R8 second done");
        bus_rd(2'd2, r); chk("R8 second received", r, 8'hC1);
        bus_wr(2'd2, 8'h77);
        slv_byte(1'b1, 1'b0, 8'h24, g);
        bus_rd(2'd1, r);
        chk("R8 no byte without reselect", r, 0);
        bus_rd(2'd2, r);
        chk("R8 data unchanged", r, 8'hC1);
        ss_n_i = 1'b1;
        repeat (SH) @(negedge clk);

        // R9 phase-1 slave, CPOL 0, select held low
        sck_i = 1'b0;
        bus_wr(2'd0, 8'h09);
        repeat (4) @(negedge clk);
        bus_wr(2'd2, 8'h6B);
        ss_n_i = 1'b0;
        repeat (SH) @(negedge clk);
        slv_byte(1'b0, 1'b1, 8'h92, g);
        chk("R9 first sent", g, 8'h6B);
        wait_spif("R9 first done");
        bus_rd(2'd2, r); chk("R9 first received", r, 8'h92);
        bus_wr(2'd2, 8'hD4);
        slv_byte(1'b0, 1'b1, 8'h1E, g);
        chk("R9 second sent", g, 8'hD4);
        wait_spif("R9 second done");
        bus_rd(2'd2, r); chk("R9 second received", r, 8'h1E);
        ss_n_i = 1'b1;
        repeat (SH) @(negedge clk);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule